// File: doc/BRIEF.md
# Serial Controller Register Bank with Prioritized Interrupt Identification

This block is the host-facing side of a byte-wide asynchronous serial controller. A host reaches eight byte registers through a 3-bit offset. Behind them sit a receive queue, a single-entry transmit holding register, a 16-bit baud divisor and the frame settings. The block also holds a prioritized interrupt source, read back as a 4-bit code, and drives a registered interrupt request line.

The serial side is abstracted away. A received byte arrives as a one-cycle `rx_valid` strobe with its data. A byte to transmit leaves through a `tx_valid`/`tx_ready` handshake. Line errors and modem-status changes arrive as one-cycle pulses. The divisor and the frame settings leave as plain outputs for the bit engine, which lies outside this block. Setting the bank bit (line control bit 7) swaps offsets 0 and 1 over to the divisor bytes.

Top module: `uart_regbank`

## Requirements
- R1: A bus read at offset A captures the register into `bus_rdata`, and the value is visible after the next rising edge. Offset 7 (scratch) returns the last byte written to it unchanged. Offset 4 (modem control) keeps and returns the low 5 bits of its last write.
- R2: When line control bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte. The data and enable registers are left untouched. `baud_div` presents the 16-bit divisor; for example, 9600 baud uses 115200/9600 = 12.
- R3: Offset 3 stores line control. `frame_cfg` mirrors bits [5:0]: [1:0] give the word length (00 = 5 bits up to 11 = 8 bits), [2] selects two stop bits, and [5:3] give the parity (000 none, 001 odd, 011 even, 101 mark, 111 space).
- R4: A write to offset 2 sets up the queue. Bit 0 enables the queue, bit 1 flushes the receive queue, and bits [7:6] pick the receive trigger level (00→1, 01→4, 10→8, 11→14 bytes). A change of bit 0 also flushes. With the queue disabled the trigger level is 1. The identification register reads bits [7:6] = 11 while the queue is enabled and 00 otherwise. Writing 0x87 therefore enables, flushes and sets a trigger level of 8.
- R5: Line status at offset 5 reads as follows: bit 0 = at least one received byte waiting; bit 1 = overrun; bits 2/3/4 = `line_err[0]`/`[1]`/`[2]`; bits 5 and 6 = transmit holding register empty; bit 7 = 0. Reading it clears bits 1 to 4.
- R6: The received-data condition (code 0x4, enable bit 0) holds while the queue count is at or above the trigger level. It does not hold merely because the queue is not empty.
- R7: Receive timeout (code 0xC, enable bit 0) fires when the queue is enabled and holds between 1 and trigger−1 bytes, and no byte has been pushed or read for `TMO_CYCLES` clocks. Reading the data register or flushing clears it.
- R8: Transmit-empty (code 0x2) becomes pending when the holding register empties while enable bit 1 is set, or when bit 1 goes from 0 to 1 while the register is empty. Three things clear it: a data write, a read of the identification register that shows code 0x2, or clearing enable bit 1.
- R9: `modem_chg` pulses accumulate into bits [3:0] of offset 6. Reading offset 6 returns them and clears them. With enable bit 3 set, they form the modem condition (code 0x0).
- R10: Identification bits [3:0] report the highest pending enabled source: line status 0x6, then received data 0x4, then timeout 0xC, then transmit empty 0x2, then modem 0x0. With nothing pending they read 0x1. Line status is enable bit 2.
- R11: `irq` is high one cycle after any enabled source is pending and low one cycle after none is.
- R12: A data write (bank bit 0) loads the holding register. `tx_valid` rises on the next cycle with that byte on `tx_data`, and both hold until `tx_ready` is seen.
- R13: The receive queue returns bytes in arrival order and holds `DEPTH` bytes. A byte that arrives while the queue is full is dropped and sets the overrun bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| line_err | input | 3 | Parity / framing / break pulses |
| modem_chg | input | 4 | Modem-status change pulses |
| tx_valid | output | 1 | Holding register full |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Bit engine accepts the byte |
| baud_div | output | 16 | Baud divisor |
| frame_cfg | output | 6 | Word length, stop bits, parity |
| irq | output | 1 | Interrupt request |

## Verification
A read issued at one rising edge is due on `bus_rdata` right after that edge. The bench records each read when it issues it and compares the value at the following falling edge. Any clearing side effect of a read takes hold at that same edge, so the next read, one cycle later, already sees it. `tx_valid`, `baud_div` and `frame_cfg` are due right after the writing edge. `irq` lags the pending state by one further register, so the bench waits an extra cycle before sampling it. The timeout takes `TMO_CYCLES` quiet clocks plus that register, so the bench waits well beyond that before checking it.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;

  typedef enum logic [2:0] {
    OFS_DATA = 3'd0,
    OFS_IER  = 3'd1,
    OFS_IIR  = 3'd2,
    OFS_LCR  = 3'd3,
    OFS_MCR  = 3'd4,
    OFS_LSR  = 3'd5,
    OFS_MSR  = 3'd6,
    OFS_SCR  = 3'd7
  } ofs_e;

  localparam logic [3:0] IID_NONE = 4'h1;
  localparam logic [3:0] IID_LS   = 4'h6;
  localparam logic [3:0] IID_RDA  = 4'h4;
  localparam logic [3:0] IID_TMO  = 4'hC;
  localparam logic [3:0] IID_THRE = 4'h2;
  localparam logic [3:0] IID_MS   = 4'h0;

  // queue trigger level chosen by the setup register bits [7:6]
  function automatic int unsigned trig_bytes(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/uart_rb_rxq.sv
module uart_rb_rxq #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  input  logic                         flush,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         empty,
  output logic                         ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign ovf     = push && full && !flush;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R13
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> (count == CW'(DEPTH))); // R13

endmodule

// File: rtl/uart_rb_tmo.sv
module uart_rb_tmo #(
  parameter int TMO_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic kick,
  input  logic clr,
  output logic fire
);
  localparam int TW = $clog2(TMO_CYCLES);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      fire <= 1'b0;
    end else begin
      if (kick || !arm)  cnt <= '0;
      else if (!fire)    cnt <= cnt + TW'(1);
      if (clr)           fire <= 1'b0;
      else if (arm && !kick && cnt == TW'(TMO_CYCLES-1)) fire <= 1'b1;
    end
  end

  AST_TMO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> !fire); // R7
  AST_TMO_ARMED: assert property (@(posedge clk) disable iff (rst)
    $rose(fire) |-> $past(arm)); // R7

endmodule

// File: rtl/uart_rb_intsel.sv
module uart_rb_intsel
  import uart_rb_pkg::*;
(
  input  logic       ls,
  input  logic       rda,
  input  logic       tmo,
  input  logic       thre,
  input  logic       ms,
  output logic [3:0] code,
  output logic       any
);
  always_comb begin
    if (ls)        code = IID_LS;
    else if (rda)  code = IID_RDA;
    else if (tmo)  code = IID_TMO;
    else if (thre) code = IID_THRE;
    else if (ms)   code = IID_MS;
    else           code = IID_NONE;
  end

  assign any = ls | rda | tmo | thre | ms;

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_rb_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int TMO_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic [2:0]  line_err,
  input  logic [3:0]  modem_chg,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        tx_ready,
  output logic [15:0] baud_div,
  output logic [5:0]  frame_cfg,
  output logic        irq
);
  localparam int CW = $clog2(DEPTH+1);

  logic [7:0]  lcr_q, scr_q, thr_q, rdata_q, rd_mux, lsr, iir;
  logic [3:0]  ier_q, lerr_q, mdelta_q, code;
  logic [4:0]  mcr_q;
  logic [15:0] div_q;
  logic [1:0]  trig_sel_q;
  logic        fifo_en_q, thr_full_q, thre_pend_q, irq_q;

  logic          dlab, wr_en, rd_en, thr_wr, ier_wr, fcr_wr;
  logic          rbr_rd, iir_rd, lsr_rd, msr_rd, flush, hs;
  logic          thre_set, thre_clr, any_pend, tmo_fire, tmo_arm;
  logic [7:0]    rx_dout;
  logic [CW-1:0] rx_cnt, trig_lvl;
  logic          rx_empty, rx_ovf;
  ofs_e          ofs;

  assign dlab   = lcr_q[7];
  assign ofs    = ofs_e'(bus_addr);
  assign wr_en  = bus_sel && bus_wr;
  assign rd_en  = bus_sel && !bus_wr;
  assign thr_wr = wr_en && ofs == OFS_DATA && !dlab;
  assign ier_wr = wr_en && ofs == OFS_IER && !dlab;
  assign fcr_wr = wr_en && ofs == OFS_IIR;
  assign rbr_rd = rd_en && ofs == OFS_DATA && !dlab;
  assign iir_rd = rd_en && ofs == OFS_IIR;
  assign lsr_rd = rd_en && ofs == OFS_LSR;
  assign msr_rd = rd_en && ofs == OFS_MSR;
  assign flush  = fcr_wr && (bus_wdata[1] || (bus_wdata[0] != fifo_en_q));
  assign hs     = thr_full_q && tx_ready;

  uart_rb_rxq #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_valid), .din(rx_data), .pop(rbr_rd),
    .flush(flush), .dout(rx_dout), .count(rx_cnt), .empty(rx_empty), .ovf(rx_ovf)
  );

  assign trig_lvl = fifo_en_q ? CW'(trig_bytes(trig_sel_q)) : CW'(1);
  assign tmo_arm  = fifo_en_q && !rx_empty && (rx_cnt < trig_lvl);

  uart_rb_tmo #(.TMO_CYCLES(TMO_CYCLES)) u_tmo (
    .clk(clk), .rst(rst), .arm(tmo_arm), .kick(rx_valid || rbr_rd),
    .clr(rbr_rd || flush), .fire(tmo_fire)
  );

  uart_rb_intsel u_isel (
    .ls(ier_q[2] && (|lerr_q)),
    .rda(ier_q[0] && (rx_cnt >= trig_lvl)),
    .tmo(ier_q[0] && tmo_fire),
    .thre(thre_pend_q),
    .ms(ier_q[3] && (|mdelta_q)),
    .code(code), .any(any_pend)
  );

  assign lsr = {1'b0, !thr_full_q, !thr_full_q, lerr_q, !rx_empty};
  assign iir = {{2{fifo_en_q}}, 2'b00, code};

  always_comb begin
    case (ofs)
      OFS_DATA: rd_mux = dlab ? div_q[7:0]  : rx_dout;
      OFS_IER:  rd_mux = dlab ? div_q[15:8] : {4'b0, ier_q};
      OFS_IIR:  rd_mux = iir;
      OFS_LCR:  rd_mux = lcr_q;
      OFS_MCR:  rd_mux = {3'b0, mcr_q};
      OFS_LSR:  rd_mux = lsr;
      OFS_MSR:  rd_mux = {4'b0, mdelta_q};
      default:  rd_mux = scr_q;
    endcase
  end

  assign thre_set = (hs && ier_q[1] && !thr_wr && !(ier_wr && !bus_wdata[1])) ||
                    (ier_wr && bus_wdata[1] && !ier_q[1] && !thr_full_q);
  assign thre_clr = thr_wr || (iir_rd && code == IID_THRE) || (ier_wr && !bus_wdata[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      lcr_q <= '0; scr_q <= '0; thr_q <= '0; rdata_q <= '0;
      ier_q <= '0; lerr_q <= '0; mdelta_q <= '0; mcr_q <= '0;
      div_q <= '0; trig_sel_q <= '0; fifo_en_q <= 1'b0;
      thr_full_q <= 1'b0; thre_pend_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      if (wr_en) begin
        case (ofs)
          OFS_DATA: if (dlab) div_q[7:0] <= bus_wdata;
          OFS_IER:  if (dlab) div_q[15:8] <= bus_wdata;
                    else      ier_q <= bus_wdata[3:0];
          OFS_IIR:  begin
                      fifo_en_q  <= bus_wdata[0];
                      trig_sel_q <= bus_wdata[7:6];
                    end
          OFS_LCR:  lcr_q <= bus_wdata;
          OFS_MCR:  mcr_q <= bus_wdata[4:0];
          OFS_SCR:  scr_q <= bus_wdata;
          default:  ;
        endcase
      end
      if (thr_wr) begin
        thr_q      <= bus_wdata;
        thr_full_q <= 1'b1;
      end else if (hs) begin
        thr_full_q <= 1'b0;
      end
      thre_pend_q <= thre_set || (thre_pend_q && !thre_clr);
      lerr_q      <= (lsr_rd ? 4'b0 : lerr_q) | {line_err, rx_ovf};
      mdelta_q    <= (msr_rd ? 4'b0 : mdelta_q) | modem_chg;
      irq_q       <= any_pend;
      if (rd_en) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata = rdata_q;
  assign tx_valid  = thr_full_q;
  assign tx_data   = thr_q;
  assign baud_div  = div_q;
  assign frame_cfg = lcr_q[5:0];
  assign irq       = irq_q;

  AST_THR_LOAD: assert property (@(posedge clk) disable iff (rst)
    thr_wr |=> (tx_valid && tx_data == $past(bus_wdata))); // R12
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !thr_wr) |=> (tx_valid && $stable(tx_data))); // R12
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (ier_q == 4'b0 && $past(ier_q) == 4'b0 && !$past(thre_pend_q)) |-> !irq); // R11
  AST_LS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd && line_err == 3'b0 && !rx_ovf) |=> (lsr[4:1] == 4'b0)); // R5

endmodule

// File: tb/sim_uart_regbank.sv
module sim_uart_regbank;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_sel, bus_wr;
  logic [2:0]  bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic [2:0]  line_err;
  logic [3:0]  modem_chg;
  logic        tx_valid, tx_ready;
  logic [7:0]  tx_data;
  logic [15:0] baud_div;
  logic [5:0]  frame_cfg;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always #2 clk = ~clk;

  uart_regbank #(.DEPTH(16), .TMO_CYCLES(32)) u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .line_err(line_err), .modem_chg(modem_chg), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .baud_div(baud_div), .frame_cfg(frame_cfg), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bw(input logic [2:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic br(input logic [2:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rxb(input logic [7:0] d);
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: a read issued at an edge is due by the next falling edge
  always @(posedge clk) rd_seen <= bus_sel && !bus_wr && !rst;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R1: read result with no expected entry, got %h expected none", bus_rdata);
      end else begin
        chk(tag_q.pop_front(), {8'h0, bus_rdata}, {8'h0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rx_valid = 1'b0; rx_data = '0; line_err = '0; modem_chg = '0; tx_ready = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    chk("R11 irq after reset", {15'h0, irq}, 16'h0);
    chk("R12 tx_valid after reset", {15'h0, tx_valid}, 16'h0);
    chk("R2 divisor after reset", baud_div, 16'h0);
    br(3'd2, 8'h01, "R10 idle identification");
    br(3'd5, 8'h60, "R5 line status after reset");

    // R1 scratch and modem control
    bw(3'd7, 8'hA5); br(3'd7, 8'hA5, "R1 scratch A5");
    bw(3'd7, 8'h3C); br(3'd7, 8'h3C, "R1 scratch 3C");
    bw(3'd4, 8'hFF); br(3'd4, 8'h1F, "R1 modem control 5 bits");

    // R2 divisor bank, R3 frame settings
    bw(3'd3, 8'h83); bw(3'd0, 8'h0C); bw(3'd1, 8'h00);
    chk("R2 divisor 9600", baud_div, 16'd12);
    br(3'd0, 8'h0C, "R2 divisor low");
    br(3'd1, 8'h00, "R2 divisor high");
    br(3'd3, 8'h83, "R3 line control with bank bit");
    bw(3'd3, 8'h1B);
    chk("R3 frame 8 bits even parity", {10'h0, frame_cfg}, 16'h1B);
    chk("R2 divisor write did not reach transmit", {15'h0, tx_valid}, 16'h0);
    br(3'd1, 8'h00, "R2 enable untouched by divisor write");

    // R4 queue setup, R6 trigger level, R13 order
    bw(3'd2, 8'h87);
    br(3'd2, 8'hC1, "R4 queue enabled flag");
    bw(3'd1, 8'h01);
    for (int i = 0; i < 7; i++) rxb(8'h10 + 8'(i));
    idle(1);
    chk("R6 no request below trigger", {15'h0, irq}, 16'h0);
    br(3'd5, 8'h61, "R5 data waiting bit");
    rxb(8'h17);
    idle(1);
    chk("R6 request at trigger", {15'h0, irq}, 16'h1);
    br(3'd2, 8'hC4, "R6 received data code");
    for (int i = 0; i < 8; i++) br(3'd0, 8'h10 + 8'(i), "R13 receive order");
    br(3'd2, 8'hC1, "R6 drained");
    idle(1);
    chk("R11 irq drops", {15'h0, irq}, 16'h0);

    // R7 timeout
    rxb(8'h21); rxb(8'h22); rxb(8'h23);
    idle(40);
    chk("R7 timeout raises irq", {15'h0, irq}, 16'h1);
    br(3'd2, 8'hCC, "R7 timeout code");
    br(3'd0, 8'h21, "R7 read clears timeout");
    br(3'd2, 8'hC1, "R7 timeout cleared");
    br(3'd0, 8'h22, "R13 order after timeout");
    br(3'd0, 8'h23, "R13 order after timeout");

    // R8 transmit empty, R12 handshake
    bw(3'd1, 8'h03);
    br(3'd2, 8'hC2, "R8 enable while empty");
    br(3'd2, 8'hC1, "R8 cleared by identification read");
    bw(3'd0, 8'h5A);
    chk("R12 tx_valid after write", {15'h0, tx_valid}, 16'h1);
    chk("R12 tx_data after write", {8'h0, tx_data}, 16'h5A);
    br(3'd5, 8'h00, "R5 holding full");
    idle(3);
    chk("R12 tx_valid held", {15'h0, tx_valid}, 16'h1);
    chk("R12 tx_data held", {8'h0, tx_data}, 16'h5A);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    chk("R12 tx_valid after accept", {15'h0, tx_valid}, 16'h0);
    idle(1);
    chk("R11 irq for transmit empty", {15'h0, irq}, 16'h1);
    br(3'd2, 8'hC2, "R8 empty after handshake");
    bw(3'd0, 8'h66);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    bw(3'd1, 8'h01);
    br(3'd2, 8'hC1, "R8 withdrawn by enable clear");

    // R10 priority, R5 and R9 clear on read
    line_err = 3'b010; modem_chg = 4'b0001;
    @(negedge clk);
    line_err = 3'b000; modem_chg = 4'b0000;
    for (int i = 0; i < 8; i++) rxb(8'h40 + 8'(i));
    bw(3'd1, 8'h0F);
    br(3'd2, 8'hC6, "R10 line status first");
    br(3'd5, 8'h69, "R5 framing bit");
    br(3'd2, 8'hC4, "R10 received data second");
    for (int i = 0; i < 8; i++) br(3'd0, 8'h40 + 8'(i), "R13 receive order");
    br(3'd2, 8'hC2, "R10 transmit empty fourth");
    br(3'd2, 8'hC0, "R10 modem last");
    br(3'd6, 8'h01, "R9 modem delta");
    br(3'd6, 8'h00, "R9 cleared on read");
    br(3'd2, 8'hC1, "R10 nothing pending");
    idle(1);
    chk("R11 irq low", {15'h0, irq}, 16'h0);

    // R13 overrun
    bw(3'd1, 8'h00);
    bw(3'd2, 8'h07);
    br(3'd5, 8'h60, "R4 flushed");
    for (int i = 0; i < 17; i++) rxb(8'h80 + 8'(i));
    br(3'd5, 8'h63, "R13 overrun flagged");
    br(3'd5, 8'h61, "R5 overrun cleared by read");
    br(3'd0, 8'h80, "R13 oldest byte kept");

    // R4 queue disabled: trigger of one, no flag bits
    bw(3'd2, 8'h00);
    br(3'd5, 8'h60, "R4 disable flushes");
    bw(3'd1, 8'h01);
    rxb(8'h77);
    idle(1);
    chk("R4 single byte request when disabled", {15'h0, irq}, 16'h1);
    br(3'd2, 8'h04, "R4 disabled identification");
    br(3'd0, 8'h77, "R4 disabled data");
    br(3'd2, 8'h01, "R4 disabled empty");
    idle(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule